// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of interrupt lines and raises a single request towards the processor. Each line has a control word with two fields: a trigger kind (active-low level, active-high level, falling edge or rising edge) and a priority. A word of enable bits decides which lines may compete. Two write-only ports change it: one turns on the lines whose data bit is 1, and the other turns them off. Lines whose data bit is 0 keep their state.

Software services an interrupt in three steps. It reads a vector port, which returns the winning line's index times four. That read also places the controller in service, so the request output stays low until software writes to an end-of-service port. The winner is the enabled, pending line with the largest priority value. When priorities are equal, the smallest index wins. A line set to an edge trigger keeps a captured edge until it is acknowledged. A line set to a level trigger is pending for as long as it holds its active level.

Top module: `vpic_top`

## Requirements
- R1: After reset every enable bit is 0, every control word reads 0, no service is active and `irq_o` is low.
- R2: The control word of line n is at byte address 4*n. Bits [7:6] hold the trigger kind (0 active-low level, 1 active-high level, 2 falling edge, 3 rising edge) and bits [2:0] hold the priority. All other bits read 0.
- R3: A write to 0x120 sets the enable bit of each line whose data bit is 1 and leaves every other enable bit as it was. The enable word reads back at 0x114.
- R4: A write to 0x124 clears the enable bit of each line whose data bit is 1 and leaves every other enable bit as it was.
- R5: A line of kind 0 is pending while its input is 0, and a line of kind 1 is pending while its input is 1.
- R6: A line of kind 3 captures a 0-to-1 transition and a line of kind 2 captures a 1-to-0 transition, whether or not the line is enabled. The capture stays until that line is acknowledged by a vector read.
- R7: The winner is the enabled, pending line with the largest priority. On equal priority the smallest index wins.
- R8: Outside service, a read of 0x10C returns the winner's index times 4 and starts service on that line. `irq_o` is then low until end-of-service. 0x110 returns the same line's plain index.
- R9: A write of any data to 0x130 ends service.
- R10: When no enabled line is pending, a read of 0x10C returns 0 and does not start service.
- R11: During service, a read of 0x10C or 0x110 returns the line being served and changes no state.
- R12: `irq_o` is high exactly when no service is active and at least one enabled line is pending. Lines that are disabled have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_rd | input | 1 | Read strobe; only its use at 0x10C has a side effect |
| bus_addr | input | ADDR_W (9) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| src_i | input | NUM_SRC (32) | Interrupt source lines |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its defaults: 32 lines and a 3-bit priority. This brings the highest index (vector 0x7C) and ties at every one of the eight priority levels within reach. A behavioural model in the bench tracks the enable word, the edge captures and the service state, and is compared against `irq_o` and `bus_rdata` on every cycle. Directed phases cover each trigger kind, set/clear of enables, tie-breaking and the empty read. A long random phase then mixes control writes, enable changes, vector reads and end-of-service writes with toggling source lines.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    TRIG_LVL_LOW   = 2'd0,
    TRIG_LVL_HIGH  = 2'd1,
    TRIG_EDGE_FALL = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

  localparam int OFS_VEC   = 'h10C;
  localparam int OFS_NUM   = 'h110;
  localparam int OFS_MASK  = 'h114;
  localparam int OFS_MSET  = 'h120;
  localparam int OFS_MCLR  = 'h124;
  localparam int OFS_EOS   = 'h130;
endpackage

// File: rtl/vpic_src.sv
module vpic_src
  import vpic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  input  logic [1:0] kind_i,
  input  logic       ack_i,
  output logic       pend_o
);
  trig_e kind;
  logic  line_q, line_d;
  logic  cap_q, cap_d;
  logic  edge_seen;

  assign kind = trig_e'(kind_i);

  always_comb begin
    unique case (kind)
      TRIG_EDGE_RISE: edge_seen = line_i & ~line_q;
      TRIG_EDGE_FALL: edge_seen = ~line_i & line_q;
      default:        edge_seen = 1'b0;
    endcase
    line_d = line_i;
    cap_d  = edge_seen | (cap_q & ~ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      cap_q  <= cap_d;
    end
  end

  always_comb begin
    unique case (kind)
      TRIG_LVL_LOW:  pend_o = ~line_i;
      TRIG_LVL_HIGH: pend_o = line_i;
      default:       pend_o = cap_q;
    endcase
  end
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             cand_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                           any_o,
  output logic [IDX_W-1:0]               win_o
);
  logic              found;
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;

  always_comb begin
    found  = 1'b0;
    best_p = '0;
    best_i = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (cand_i[n] && (!found || (prio_i[n] > best_p))) begin
        found  = 1'b1;
        best_p = prio_i[n];
        best_i = IDX_W'(n);
      end
    end
  end

  assign any_o = found;
  assign win_o = best_i;
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam int WORD_W = ADDR_W - 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // address decode
  logic             ctrl_hit;
  logic [IDX_W-1:0] ctrl_idx;
  logic             hit_vec, hit_num, hit_mask, hit_mset, hit_mclr, hit_eos;

  assign ctrl_hit = (bus_addr[1:0] == 2'b00) &&
                    (bus_addr[ADDR_W-1:2] < WORD_W'(NUM_SRC));
  assign ctrl_idx = bus_addr[2 +: IDX_W];
  assign hit_vec  = (bus_addr == ADDR_W'(OFS_VEC));
  assign hit_num  = (bus_addr == ADDR_W'(OFS_NUM));
  assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
  assign hit_mset = (bus_addr == ADDR_W'(OFS_MSET));
  assign hit_mclr = (bus_addr == ADDR_W'(OFS_MCLR));
  assign hit_eos  = (bus_addr == ADDR_W'(OFS_EOS));

  // per-line control words and condition logic
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_all;
  logic [NUM_SRC-1:0][1:0]        kind_all;
  logic [NUM_SRC-1:0]             pend;
  logic [NUM_SRC-1:0]             ack;
  logic                           any_cand;
  logic [IDX_W-1:0]               win;
  logic                           entry;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    logic              we;
    logic [PRIO_W-1:0] p_q, p_d;
    logic [1:0]        k_q, k_d;

    assign we = bus_wr && ctrl_hit && (ctrl_idx == IDX_W'(g));

    always_comb begin
      p_d = p_q;
      k_d = k_q;
      if (we) begin
        p_d = bus_wdata[PRIO_W-1:0];
        k_d = bus_wdata[7:6];
      end
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        p_q <= '0;
        k_q <= 2'b00;
      end else if (we) begin
        p_q <= p_d;
        k_q <= k_d;
      end
    end

    assign prio_all[g] = p_q;
    assign kind_all[g] = k_q;
    assign ack[g]      = entry && (win == IDX_W'(g));

    vpic_src u_src (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .line_i (src_i[g]),
      .kind_i (k_q),
      .ack_i  (ack[g]),
      .pend_o (pend[g])
    );
  end

  // enable word
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic               mask_en;

  assign mask_en = bus_wr && (hit_mset || hit_mclr);

  always_comb begin
    mask_d = mask_q;
    if (hit_mset) mask_d = mask_q | bus_wdata[NUM_SRC-1:0];
    if (hit_mclr) mask_d = mask_q & ~bus_wdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  // arbitration
  vpic_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .cand_i (pend & mask_q),
    .prio_i (prio_all),
    .any_o  (any_cand),
    .win_o  (win)
  );

  // service state
  logic             svc_q, svc_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic             eos;

  assign entry = bus_rd && hit_vec && !svc_q && any_cand;
  assign eos   = bus_wr && hit_eos;

  always_comb begin
    svc_d = svc_q;
    cur_d = cur_q;
    if (entry) begin
      svc_d = 1'b1;
      cur_d = win;
    end else if (eos) begin
      svc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      svc_q <= 1'b0;
      cur_q <= '0;
    end else begin
      svc_q <= svc_d;
      if (entry) cur_q <= cur_d;
    end
  end

  assign irq_o = !svc_q && any_cand;

  // read mux
  logic             vec_valid;
  logic [IDX_W-1:0] vec_src;

  assign vec_valid = svc_q || any_cand;
  assign vec_src   = svc_q ? cur_q : win;

  always_comb begin
    bus_rdata = '0;
    if (ctrl_hit) begin
      bus_rdata[7:6]        = kind_all[ctrl_idx];
      bus_rdata[PRIO_W-1:0] = prio_all[ctrl_idx];
    end else if (hit_mask) begin
      bus_rdata = DATA_W'(mask_q);
    end else if (hit_vec) begin
      if (vec_valid) bus_rdata = DATA_W'({vec_src, 2'b00});
    end else if (hit_num) begin
      if (vec_valid) bus_rdata = DATA_W'(vec_src);
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:8], bus_wdata[5:PRIO_W]};
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker
  import vpic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 9
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               svc_q
);
  logic a_vec, a_mset, a_mclr, a_eos;
  assign a_vec  = (bus_addr == ADDR_W'(OFS_VEC));
  assign a_mset = (bus_addr == ADDR_W'(OFS_MSET));
  assign a_mclr = (bus_addr == ADDR_W'(OFS_MCLR));
  assign a_eos  = (bus_addr == ADDR_W'(OFS_EOS));

  assert_enable_sets_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && a_mset) |=>
      ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

  assert_mask_holds_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_wr && (a_mset || a_mclr)) |=> $stable(mask_q));

  assert_disable_clears_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && a_mclr) |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

  assert_quiet_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && a_vec && irq_o && !(bus_wr && a_eos)) |=> !irq_o);

  assert_vec_aligned_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    a_vec |-> (bus_rdata[1:0] == 2'b00));

  assert_eos_release_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && a_eos && !bus_rd) |=> !svc_q);

  assert_empty_zero_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && a_vec && !irq_o && !svc_q) |-> (bus_rdata == '0));

  assert_empty_idle_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && a_vec && !irq_o && !svc_q) |=> !svc_q);
endmodule

bind vpic_top vpic_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .mask_q    (mask_q),
  .svc_q     (svc_q)
);

// File: tb/vpic_top_bench.sv
`timescale 1ns/1ps
module vpic_top_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] src;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  vpic_top u_vpic_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_i(src), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural model
  int          m_kind [32];
  int          m_prio [32];
  logic [31:0] m_en, m_cap, m_prev;
  bit          m_svc;
  int          m_cur;

  function automatic bit m_pend(int n);
    case (m_kind[n])
      0:       return !src[n];
      1:       return src[n];
      default: return m_cap[n];
    endcase
  endfunction

  function automatic int m_win(output bit any);
    int bp = 0;
    int bi = 0;
    any = 0;
    for (int n = 0; n < 32; n++)
      if (m_en[n] && m_pend(n) && (!any || m_prio[n] > bp)) begin
        any = 1; bp = m_prio[n]; bi = n;
      end
    return bi;
  endfunction

  function automatic logic [31:0] m_read(logic [8:0] a);
    bit any;
    int w = m_win(any);
    int s = m_svc ? m_cur : w;
    bit v = m_svc || any;
    if (a < 128 && a[1:0] == 0) return (32'(m_kind[a/4]) << 6) | 32'(m_prio[a/4]);
    if (a == 9'h114) return m_en;
    if (a == 9'h10C) return v ? 32'(s * 4) : 32'd0;
    if (a == 9'h110) return v ? 32'(s) : 32'd0;
    return 32'd0;
  endfunction

  function automatic void m_update();
    bit any;
    int w = m_win(any);
    bit entry = bus_rd && bus_addr == 9'h10C && !m_svc && any;
    for (int n = 0; n < 32; n++) begin
      bit e = (m_kind[n] == 3 && !m_prev[n] && src[n]) ||
              (m_kind[n] == 2 && m_prev[n] && !src[n]);
      m_cap[n] = e || (m_cap[n] && !(entry && w == n));
    end
    m_prev = src;
    if (bus_wr) begin
      if (bus_addr < 128 && bus_addr[1:0] == 0) begin
        m_kind[bus_addr/4] = int'(bus_wdata[7:6]);
        m_prio[bus_addr/4] = int'(bus_wdata[2:0]);
      end
      if (bus_addr == 9'h120) m_en = m_en | bus_wdata;
      if (bus_addr == 9'h124) m_en = m_en & ~bus_wdata;
    end
    if (entry) begin
      m_svc = 1; m_cur = w;
    end else if (bus_wr && bus_addr == 9'h130) m_svc = 0;
  endfunction

  task automatic tick(input string tag);
    bit any;
    bit ei;
    logic [31:0] er;
    #1;
    void'(m_win(any));
    ei = !m_svc && any;
    checks++;
    if (irq_o !== ei) begin
      fails++;
      $display("FAIL %s irq_o actual %0b expected %0b", tag, irq_o, ei);
    end
    er = m_read(bus_addr);
    checks++;
    if (bus_rdata !== er) begin
      fails++;
      $display("FAIL %s rdata@%h actual %h expected %h", tag, bus_addr, bus_rdata, er);
    end
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input string tag);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    tick(tag);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [8:0] a, input string tag);
    bus_addr = a; bus_rd = 1;
    tick(tag);
    bus_rd = 0;
  endtask

  task automatic idle(input string tag);
    bus_addr = 9'h10C;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; src = '0;
    for (int n = 0; n < 32; n++) begin m_kind[n] = 0; m_prio[n] = 0; end
    m_en = '0; m_cap = '0; m_prev = '0; m_svc = 0; m_cur = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rd(9'h114, "R1"); rd(9'h000, "R1"); rd(9'h07C, "R1"); rd(9'h110, "R1");
    // R2 control word layout
    wr(9'h014, 32'hFFFF_FF45, "R2"); rd(9'h014, "R2");
    // R12 disabled line, then R3 enable
    src[5] = 1; idle("R12");
    wr(9'h120, 32'h20, "R3"); rd(9'h114, "R3");
    // R8 / R11 service
    rd(9'h10C, "R8"); rd(9'h110, "R8"); idle("R8");
    rd(9'h10C, "R11"); rd(9'h110, "R11");
    wr(9'h130, 32'h1234, "R9"); idle("R9");
    src[5] = 0; idle("R5");
    // R7 priority and tie
    wr(9'h00C, 32'h45, "R7"); wr(9'h024, 32'h46, "R7"); wr(9'h008, 32'h46, "R7");
    wr(9'h120, 32'h20C, "R7");
    src[3] = 1; src[9] = 1; src[2] = 1; idle("R7");
    rd(9'h10C, "R7"); wr(9'h130, 0, "R9");
    wr(9'h124, 32'h4, "R4"); rd(9'h114, "R4");
    rd(9'h10C, "R7"); wr(9'h130, 0, "R9");
    wr(9'h124, 32'hFFFF_FFFF, "R4"); rd(9'h114, "R4"); idle("R12");
    src = '0; idle("R12");
    // R6 edges, captured while disabled
    wr(9'h030, 32'hC1, "R6"); wr(9'h034, 32'h81, "R6");
    src[12] = 1; idle("R6"); src[12] = 0; idle("R6");
    wr(9'h120, 32'h3000, "R6"); idle("R6");
    rd(9'h10C, "R6"); wr(9'h130, 0, "R6"); idle("R6");
    src[13] = 1; idle("R6"); src[13] = 0; idle("R6"); idle("R6");
    rd(9'h10C, "R6"); wr(9'h130, 0, "R6"); idle("R6");
    // R5 active-low level
    wr(9'h050, 32'h03, "R5"); wr(9'h120, 32'h0010_0000, "R5"); idle("R5");
    rd(9'h10C, "R5"); wr(9'h130, 0, "R5");
    src[20] = 1; idle("R5");
    // R10 empty read
    wr(9'h124, 32'hFFFF_FFFF, "R10"); rd(9'h10C, "R10"); rd(9'h110, "R10"); idle("R10");
    // top index and random mix
    wr(9'h07C, 32'h47, "R7"); src[31] = 1; wr(9'h120, 32'h8000_0000, "R7");
    rd(9'h10C, "R7"); wr(9'h130, 0, "R9");
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) src[$urandom_range(0, 31)] ^= 1'b1;
      case (op)
        0: wr(9'($urandom_range(0, 31) * 4), $urandom, "R7");
        1: wr(9'h120, $urandom & $urandom, "R3");
        2: wr(9'h124, $urandom & $urandom, "R4");
        3, 4: rd(9'h10C, "R8");
        5: wr(9'h130, $urandom, "R9");
        6: rd(9'h110, "R11");
        7: rd(9'h114, "R3");
        default: idle("R12");
      endcase
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule